// File: doc/BRIEF.md
# Clarke-Park Vector Rotation Engine

This block is a synchronous fixed-point datapath for field-oriented current processing. Phase samples enter on three signed inputs. A Clarke stage turns them into an orthogonal alpha/beta pair. A Park stage then rotates that pair by a 12-bit digital angle. The un-rotated pair and the rotated pair are both outputs. A two-bit mode input selects one of three input formats: two orthogonal inputs, three 120-degree phases, or two of the three phases, in which case the missing phase is rebuilt inside the block.

The angle word is qualified by a strobe. The word is captured when the strobe rises. The conversion starts when the strobe falls. At that point a busy flag is raised for a fixed number of clock cycles. When busy drops, new sine and cosine coefficients take effect. Until the next conversion, every incoming sample is multiplied by those coefficients on every clock. To rotate in reverse, apply the two's-complement negated angle.

Top module: `vec_rot_engine`

## Requirements
- R1: With mode_i = 2'b00, alpha_o equals in0_i and beta_o equals in1_i exactly. in2_i is not used.
- R2: With mode_i = 2'b01 (three phases a=in0_i, b=in1_i, c=in2_i), alpha_o = (2a-b-c)/3 and beta_o = (b-c)/sqrt(3), each within 2 LSB. Mode 2'b11 behaves the same way.
- R3: With mode_i = 2'b10, in0_i is ignored and phase a is rebuilt as -(b+c) before the R2 formulas are applied, so alpha_o is about -(in1_i+in2_i).
- R4: The angle is sampled from angle_i on the clock where strobe_i is first seen high. Changes to angle_i after that clock do not affect the conversion. Bit 11 is the MSB, and one LSB equals 2*pi/4096 rad.
- R5: The first clock that sees strobe_i low after it was high, while busy_o is low, raises busy_o on the next edge. busy_o then stays high for exactly BUSY_CYC cycles.
- R6: While busy_o is high the rotation coefficients do not change. A strobe pulse during busy does not restart the conversion. The coefficients change only on the edge where busy_o falls.
- R7: d_rot_o = alpha*cos(phi) - beta*sin(phi) and q_rot_o = alpha*sin(phi) + beta*cos(phi), within 4 LSB, using Q1.15 coefficients.
- R8: Rotated results that exceed the 16-bit signed range saturate to 32767 or -32768.
- R9: Applying the angle 4096-phi rotates by -phi.
- R10: After reset, busy_o and all data outputs are 0, and the active angle is 0, so the rotated pair equals the un-rotated pair to within 1 LSB.
- R11: alpha_o and beta_o reflect the inputs one clock after they are presented. The rotated pair follows one clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Input format select |
| in0_i | input | 16 | Phase a, or orthogonal alpha input |
| in1_i | input | 16 | Phase b, or orthogonal beta input |
| in2_i | input | 16 | Phase c |
| angle_i | input | 12 | Rotation angle, natural binary |
| strobe_i | input | 1 | Angle qualifier: capture on rise, start on fall |
| busy_o | output | 1 | Coefficient load window |
| alpha_o | output | 16 | Un-rotated orthogonal component, real part |
| beta_o | output | 16 | Un-rotated orthogonal component, imaginary part |
| d_rot_o | output | 16 | Rotated real component |
| q_rot_o | output | 16 | Rotated imaginary component |

## Verification
The bench changes angle_i immediately after the strobe rise. A design that sampled the angle late would therefore rotate by the wrong angle. It fires a second strobe pulse in the middle of the busy window. A design that restarted the conversion, or let the new angle through, would lengthen busy or move the rotated outputs before the window closes. It drives rotations at 45 and 135 degrees with full-scale inputs, so that a design without saturation wraps to the wrong sign. It drives a large, conflicting value on in0_i in the two-of-three mode to catch a design that still reads it.

// File: rtl/vr_pkg.sv
package vr_pkg;
  typedef enum logic [1:0] {
    MODE_ORTHO = 2'b00,
    MODE_TRI   = 2'b01,
    MODE_DUO   = 2'b10,
    MODE_RSVD  = 2'b11
  } in_mode_e;
endpackage

// File: rtl/vr_angle_ctrl.sv
module vr_angle_ctrl #(
  parameter int ANGLE_W  = 12,
  parameter int BUSY_CYC = 100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  logic [ANGLE_W-1:0] angle_i,
  output logic               busy_o,
  output logic               load_o,
  output logic [ANGLE_W-1:0] cmd_angle_o
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic               stb_q;
  logic [ANGLE_W-1:0] held_q;
  logic [CW-1:0]      cnt_q;
  logic               rise, fall;

  assign rise   = strobe_i & ~stb_q;
  assign fall   = ~strobe_i & stb_q;
  assign load_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q       <= 1'b0;
      held_q      <= '0;
      cnt_q       <= '0;
      busy_o      <= 1'b0;
      cmd_angle_o <= '0;
    end else begin
      stb_q <= strobe_i;
      if (rise) held_q <= angle_i;
      if (busy_o) begin
        if (cnt_q == '0) busy_o <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end else if (fall) begin
        busy_o      <= 1'b1;
        cnt_q       <= CW'(BUSY_CYC - 1);
        cmd_angle_o <= held_q;
      end
    end
  end

  p_busy_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !busy_o) |=> (busy_o && cmd_angle_o == $past(held_q)));
  p_busy_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_o) |=> busy_o);
  p_busy_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !busy_o);
  p_no_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cmd_angle_o));
endmodule

// File: rtl/vr_sincos.sv
module vr_sincos #(
  parameter int ANGLE_W = 12,
  parameter int COEF_W  = 16
) (
  input  logic [ANGLE_W-1:0]       angle_i,
  output logic signed [COEF_W-1:0] sin_o,
  output logic signed [COEF_W-1:0] cos_o
);
  localparam int QTR  = 1 << (ANGLE_W - 2);
  localparam int IW   = ANGLE_W - 1;
  localparam int CMAX = (1 << (COEF_W - 1)) - 1;

  function automatic int quarter_sin(input int k);
    real ph;
    int  v;
    ph = 3.141592653589793 * real'(k) / real'(2 * QTR);
    v  = $rtoi($sin(ph) * real'(CMAX + 1) + 0.5);
    if (v > CMAX) v = CMAX;
    return v;
  endfunction

  logic signed [COEF_W-1:0] tab [QTR+1];

  for (genvar k = 0; k <= QTR; k++) begin : g_tab
    localparam int VAL = quarter_sin(k);
    assign tab[k] = COEF_W'(VAL);
  end

  logic [ANGLE_W-1:0]       ang [2];
  logic signed [COEF_W-1:0] res [2];
  assign ang[0] = angle_i;
  assign ang[1] = angle_i + ANGLE_W'(QTR);

  // lane 0: sine, lane 1: cosine as sine shifted by a quarter turn
  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [IW-1:0]            idx, mir;
    logic signed [COEF_W-1:0] mag;
    always_comb begin
      idx = {1'b0, ang[l][ANGLE_W-3:0]};
      mir = IW'(QTR) - idx;
      mag = ang[l][ANGLE_W-2] ? tab[mir] : tab[idx];
      res[l] = ang[l][ANGLE_W-1] ? -mag : mag;
    end
  end

  assign sin_o = res[0];
  assign cos_o = res[1];
endmodule

// File: rtl/vr_clarke.sv
module vr_clarke
  import vr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               mode_i,
  input  logic signed [DATA_W-1:0] in0_i,
  input  logic signed [DATA_W-1:0] in1_i,
  input  logic signed [DATA_W-1:0] in2_i,
  output logic signed [DATA_W-1:0] alpha_o,
  output logic signed [DATA_W-1:0] beta_o
);
  localparam int SW = DATA_W + 3;
  localparam int KS = 16;
  localparam int PW = SW + KS + 2;
  localparam logic signed [PW-1:0] K_THIRD = PW'(21845);  // 2^16/3
  localparam logic signed [PW-1:0] K_ISQ3  = PW'(37837);  // 2^16/sqrt(3)
  localparam logic signed [PW-1:0] HALF    = PW'(1) <<< (KS - 1);
  localparam logic signed [PW-1:0] P_MAX   = PW'((1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [PW-1:0] P_MIN   = -P_MAX - PW'(1);

  function automatic logic signed [DATA_W-1:0] sat(input logic signed [PW-1:0] v);
    if (v > P_MAX)      return DATA_W'(P_MAX);
    else if (v < P_MIN) return DATA_W'(P_MIN);
    else                return DATA_W'(v);
  endfunction

  in_mode_e                 mode;
  logic signed [SW-1:0]     a_x, b_x, c_x, num_a, num_b;
  logic signed [PW-1:0]     prod_a, prod_b;
  logic signed [DATA_W-1:0] alpha_n, beta_n;

  always_comb begin
    mode  = in_mode_e'(mode_i);
    b_x   = SW'(in1_i);
    c_x   = SW'(in2_i);
    a_x   = (mode == MODE_DUO) ? -(b_x + c_x) : SW'(in0_i);
    num_a = (a_x <<< 1) - b_x - c_x;
    num_b = b_x - c_x;
    prod_a = (PW'(num_a) * K_THIRD + HALF) >>> KS;
    prod_b = (PW'(num_b) * K_ISQ3 + HALF) >>> KS;
    if (mode == MODE_ORTHO) begin
      alpha_n = in0_i;
      beta_n  = in1_i;
    end else begin
      alpha_n = sat(prod_a);
      beta_n  = sat(prod_b);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alpha_o <= '0;
      beta_o  <= '0;
    end else begin
      alpha_o <= alpha_n;
      beta_o  <= beta_n;
    end
  end

  p_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> (alpha_o == $past(in0_i) && beta_o == $past(in1_i)));
  p_zero_diff_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && in1_i == in2_i) |=> (beta_o == '0));
endmodule

// File: rtl/vr_park.sv
module vr_park #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     busy_i,
  input  logic                     load_i,
  input  logic signed [COEF_W-1:0] sin_i,
  input  logic signed [COEF_W-1:0] cos_i,
  input  logic signed [DATA_W-1:0] alpha_i,
  input  logic signed [DATA_W-1:0] beta_i,
  output logic signed [DATA_W-1:0] d_o,
  output logic signed [DATA_W-1:0] q_o
);
  localparam int PW = DATA_W + COEF_W + 1;
  localparam logic signed [PW-1:0] HALF  = PW'(1) <<< (COEF_W - 2);
  localparam logic signed [PW-1:0] P_MAX = PW'((1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [PW-1:0] P_MIN = -P_MAX - PW'(1);

  function automatic logic signed [DATA_W-1:0] sat(input logic signed [PW-1:0] v);
    if (v > P_MAX)      return DATA_W'(P_MAX);
    else if (v < P_MIN) return DATA_W'(P_MIN);
    else                return DATA_W'(v);
  endfunction

  logic signed [COEF_W-1:0] sin_r, cos_r;
  logic signed [PW-1:0]     acc_d, acc_q;

  always_comb begin
    acc_d = (PW'(alpha_i) * PW'(cos_r) - PW'(beta_i) * PW'(sin_r) + HALF) >>> (COEF_W - 1);
    acc_q = (PW'(alpha_i) * PW'(sin_r) + PW'(beta_i) * PW'(cos_r) + HALF) >>> (COEF_W - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_r <= '0;
      cos_r <= COEF_W'(P_MAX);
      d_o   <= '0;
      q_o   <= '0;
    end else begin
      if (load_i) begin
        sin_r <= sin_i;
        cos_r <= cos_i;
      end
      d_o <= sat(acc_d);
      q_o <= sat(acc_q);
    end
  end

  p_coef_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(sin_r) && $stable(cos_r)));
  p_load_in_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> busy_i);
endmodule

// File: rtl/vec_rot_engine.sv
module vec_rot_engine #(
  parameter int DATA_W   = 16,
  parameter int COEF_W   = 16,
  parameter int ANGLE_W  = 12,
  parameter int BUSY_CYC = 100
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               mode_i,
  input  logic signed [DATA_W-1:0] in0_i,
  input  logic signed [DATA_W-1:0] in1_i,
  input  logic signed [DATA_W-1:0] in2_i,
  input  logic [ANGLE_W-1:0]       angle_i,
  input  logic                     strobe_i,
  output logic                     busy_o,
  output logic signed [DATA_W-1:0] alpha_o,
  output logic signed [DATA_W-1:0] beta_o,
  output logic signed [DATA_W-1:0] d_rot_o,
  output logic signed [DATA_W-1:0] q_rot_o
);
  logic                     load;
  logic [ANGLE_W-1:0]       cmd_angle;
  logic signed [COEF_W-1:0] sin_v, cos_v;

  vr_angle_ctrl #(.ANGLE_W(ANGLE_W), .BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk_i, .rst_ni, .strobe_i, .angle_i,
    .busy_o, .load_o(load), .cmd_angle_o(cmd_angle)
  );

  vr_sincos #(.ANGLE_W(ANGLE_W), .COEF_W(COEF_W)) u_lut (
    .angle_i(cmd_angle), .sin_o(sin_v), .cos_o(cos_v)
  );

  vr_clarke #(.DATA_W(DATA_W)) u_clarke (
    .clk_i, .rst_ni, .mode_i, .in0_i, .in1_i, .in2_i, .alpha_o, .beta_o
  );

  vr_park #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_park (
    .clk_i, .rst_ni, .busy_i(busy_o), .load_i(load),
    .sin_i(sin_v), .cos_i(cos_v), .alpha_i(alpha_o), .beta_i(beta_o),
    .d_o(d_rot_o), .q_o(q_rot_o)
  );

  p_stage_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && $stable(in0_i) && $stable(in1_i) && alpha_o == in0_i
     && beta_o == in1_i) |=> (alpha_o == $past(alpha_o)));
endmodule

// File: tb/tb_vec_rot_engine.sv
module tb_vec_rot_engine;
  localparam int BUSY_CYC = 100;
  localparam real PI = 3.141592653589793;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode = 2'b00;
  logic signed [15:0] in0 = '0, in1 = '0, in2 = '0;
  logic [11:0]       angle = '0;
  logic              strobe = 1'b0;
  logic              busy;
  logic signed [15:0] alpha, beta, d_rot, q_rot;

  always #10 clk = ~clk;  // 50 MHz

  vec_rot_engine #(.BUSY_CYC(BUSY_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .in0_i(in0), .in1_i(in1),
    .in2_i(in2), .angle_i(angle), .strobe_i(strobe), .busy_o(busy),
    .alpha_o(alpha), .beta_o(beta), .d_rot_o(d_rot), .q_rot_o(q_rot)
  );

  typedef struct {string tag; int sel; int lit; int exp; int tol;} item_t;
  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  int phi_cur = 0;
  bit done = 1'b0;

  function automatic int rnd(real x);
    int v;
    v = (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  task automatic push(string tag, int sel, int lit, int exp, int tol);
    item_t it;
    it.tag = tag; it.sel = sel; it.lit = lit; it.exp = exp; it.tol = tol;
    sb.push_back(it);
  endtask

  // monitor: sel 0 alpha, 1 beta, 2 d_rot, 3 q_rot, 4 busy, 5 literal
  initial forever begin
    @(negedge clk);
    while (sb.size() > 0) begin
      item_t it;
      int act, diff;
      it = sb.pop_front();
      case (it.sel)
        0: act = int'(alpha);
        1: act = int'(beta);
        2: act = int'(d_rot);
        3: act = int'(q_rot);
        4: act = int'(busy);
        default: act = it.lit;
      endcase
      diff = act - it.exp;
      if (diff < 0) diff = -diff;
      n_chk++;
      if (diff > it.tol) begin
        n_fail++;
        $display("FAIL %s: actual %0d expected %0d (tol %0d)", it.tag, act, it.exp, it.tol);
      end
    end
  end

  task automatic wait_sb();
    while (sb.size() > 0) @(posedge clk);
  endtask

  // driver: apply a sample, compute expected Clarke and Park results
  task automatic apply(string tag, logic [1:0] m, int x0, int x1, int x2);
    real a, b, c, ea, eb, ph;
    int ia, ib, tol;
    @(negedge clk);
    mode = m; in0 = 16'(x0); in1 = 16'(x1); in2 = 16'(x2);
    repeat (3) @(posedge clk);
    if (m == 2'b00) begin
      ea = real'(x0); eb = real'(x1); tol = 0;
    end else begin
      b = real'(x1); c = real'(x2);
      a = (m == 2'b10) ? -(b + c) : real'(x0);
      ea = (2.0 * a - b - c) / 3.0;
      eb = (b - c) / $sqrt(3.0);
      tol = 2;
    end
    ia = rnd(ea); ib = rnd(eb);
    push({tag, " alpha"}, 0, 0, ia, tol);
    push({tag, " beta"}, 1, 0, ib, tol);
    ph = 2.0 * PI * real'(phi_cur) / 4096.0;
    push({tag, " R7 d_rot"}, 2, 0, rnd(ea * $cos(ph) - eb * $sin(ph)), 4);
    push({tag, " R7 q_rot"}, 3, 0, rnd(ea * $sin(ph) + eb * $cos(ph)), 4);
    wait_sb();
  endtask

  task automatic load_angle(int ang, bit disturb);
    int cnt, d_before;
    @(negedge clk);
    strobe = 1'b1; angle = 12'(ang);
    @(negedge clk);
    strobe = 1'b0; angle = 12'(ang) ^ 12'hA5A;  // R4: late change ignored
    @(negedge clk);
    push("R5 busy raised", 4, 0, 1, 0);
    d_before = int'(d_rot);
    cnt = 1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (disturb && cnt == 20) begin strobe = 1'b1; angle = 12'(ang + 1000); end
      if (disturb && cnt == 22) strobe = 1'b0;
      if (cnt == 50) push("R6 d_rot stable in busy", 5, int'(d_rot), d_before, 0);
      if (busy) cnt++;
      else break;
    end
    push("R5 busy length", 5, cnt, BUSY_CYC, 0);
    repeat (5) @(negedge clk);
    push("R6 no restart", 4, 0, 0, 0);
    phi_cur = ang;
    repeat (2) @(negedge clk);
    wait_sb();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    push("R10 reset busy", 4, 0, 0, 0);
    push("R10 reset alpha", 0, 0, 0, 0);
    push("R10 reset d_rot", 2, 0, 0, 0);
    rst_n = 1'b1;
    wait_sb();

    // R10: identity rotation before any angle load
    apply("R10 identity", 2'b00, 1000, -2000, 0);

    // R11: stage latency
    @(negedge clk);
    in0 = 16'sd500; in1 = 16'sd700;
    @(posedge clk);
    push("R11 alpha after one clock", 0, 0, 500, 0);
    push("R11 d_rot still old", 2, 0, 1000, 1);
    @(posedge clk);
    push("R11 d_rot after two clocks", 2, 0, 500, 1);
    wait_sb();

    // R1 orthogonal passthrough, in2 unused
    apply("R1 ortho", 2'b00, -12345, 23456, 32000);
    apply("R1 ortho neg", 2'b00, -32768, 32767, -5);

    // R2 three-phase, and reserved mode
    apply("R2 tri balanced", 2'b01, 10000, -5000, -5000);
    apply("R2 tri skew", 2'b01, 3000, 12000, -20000);
    apply("R2 tri rsvd", 2'b11, -7000, 4000, 9000);

    // R3 two-of-three, in0 garbage
    apply("R3 duo", 2'b10, 32767, 6000, -11000);
    apply("R3 duo neg", 2'b10, -32768, -9000, -2000);

    // R4 R5 R7: load angle and rotate
    load_angle(300, 1'b0);
    apply("R4 R7 ang300", 2'b00, 8000, 3000, 0);
    load_angle(1024, 1'b1);
    apply("R6 R7 ang1024", 2'b00, 8000, 3000, 0);
    load_angle(2048, 1'b0);
    apply("R7 ang2048", 2'b00, -15000, 9000, 0);
    load_angle(3000, 1'b0);
    apply("R7 ang3000 tri", 2'b01, 12000, -4000, -8000);

    // R9 reverse rotation
    load_angle(4096 - 300, 1'b0);
    apply("R9 reverse", 2'b00, 8000, 3000, 0);

    // R8 saturation
    load_angle(512, 1'b0);
    apply("R8 sat pos", 2'b00, 32767, 32767, 0);
    load_angle(1536, 1'b0);
    apply("R8 sat neg", 2'b00, 32767, 32767, 0);

    wait_sb();
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule